// File: doc/BRIEF.md
# GPIO Interrupt Latch with Split Latch and Report Enables

This block watches a bank of general-purpose input pins and turns selected pin activity into interrupts. Every pin passes through a two-stage synchroniser and then reaches its own detector. The detector can fire on a high level, a low level, a rising edge or a falling edge. A firing detector sets a sticky per-pin pending bit. The pending bits of all pins, each masked by its own report enable, are OR-ed into one summary interrupt toward the processor.

Two separate bits gate each pin. The capture enable decides whether a detector firing may set the pending bit at all. The report enable decides only whether a set pending bit reaches the summary line. Because of this split, a level source that is still active captures again right after software clears it, unless capture is switched off. For edge pins, switching capture on while the input already sits at its active level records one spurious edge.

Software reaches the block through a plain register port. A write is accepted in the cycle it is presented, and there is no back-pressure. A read returns the addressed register combinationally, in the same cycle.

Top module: `gpio_irq_bank`

## Requirements
- R1: Pin mode is a 2-bit field: 0 fires while the synchronised input is 1, 1 fires while it is 0, 2 fires on a 0-to-1 change, 3 fires on a 1-to-0 change. The pending bit for an input change presented before clock edge k is visible after edge k+2.
- R2: While a pin's capture enable is 0, its pending bit never becomes set, whatever the input does.
- R3: With capture enable 1 and report enable 0, a firing still sets the pending bit, but the summary line stays low for that pin.
- R4: Writing 1 to a pending bit clears it after that edge. If the detector fires in the same cycle, the bit stays set, so a still-active level pin with capture enabled remains pending. With capture disabled the same clear takes effect.
- R5: A pending bit stays set after the input returns to its inactive level, until software clears it. Zero bits in a clear write leave the matching pending bits unchanged.
- R6: The summary output is 1 exactly when at least one pin has both its pending bit and its report enable set. It follows register changes in the same cycle.
- R7: An edge pin records one event per qualifying transition. Holding the input at its active level after a clear does not set the pending bit again.
- R8: When the capture enable of an edge pin goes from 0 to 1 while the synchronised input is already at the edge's final level, the pending bit is set one edge after the enabling write.
- R9: Address i (for i below the pin count) holds pin i's setup: bits [1:0] mode, bit 2 capture enable, bit 3 report enable. Address equal to the pin count reads the pending bits and accepts write-one-to-clear. All other addresses read 0.
- R10: After reset, all setups read 0, no pin is pending and the summary output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpio_i | input | NUM_PINS | Asynchronous pin inputs |
| reg_we | input | 1 | Register write strobe, accepted every cycle |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| irq_summary_o | output | 1 | Combined interrupt toward the processor |

## Verification
A pin change reaches the pending bit three clock edges after it is driven: two synchroniser stages, then the pending register. Register writes take effect at the first edge. A capture that a write makes possible lands one edge after that. The summary and the read data follow the registers with no further delay. The bench drives inputs on falling clock edges and reads on the next falling edge. The directed checks count out exactly these edges, including a look at the edge before a result is due, where the old value must still show. In the random phase, a bench-side reference model steps on every rising edge and is compared against the outputs on each falling edge.

// File: rtl/gib_pkg.sv
package gib_pkg;
  typedef enum logic [1:0] {
    MODE_HIGH = 2'd0,
    MODE_LOW  = 2'd1,
    MODE_RISE = 2'd2,
    MODE_FALL = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic      report_en;
    logic      capture_en;
    pin_mode_e mode;
  } pin_setup_t;

  localparam int SETUP_W = $bits(pin_setup_t);
endpackage

// File: rtl/gib_sync.sv
module gib_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gib_pin_detect.sv
module gib_pin_detect
  import gib_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  pin_setup_t setup_i,
  input  logic       clear_i,
  output logic       pending_o
);
  logic hist_q;
  logic pend_q;
  logic fire;
  logic hist_idle;

  // Edge history parks at the level that precedes the edge while capture is off.
  assign hist_idle = (setup_i.mode == MODE_FALL);

  always_comb begin
    unique case (setup_i.mode)
      MODE_HIGH: fire = level_i;
      MODE_LOW:  fire = !level_i;
      MODE_RISE: fire = level_i && !hist_q;
      MODE_FALL: fire = !level_i && hist_q;
      default:   fire = 1'b0;
    endcase
    fire = fire && setup_i.capture_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      hist_q <= setup_i.capture_en ? level_i : hist_idle;
      pend_q <= (pend_q && !clear_i) || fire;
    end
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gib_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = $clog2(NUM_PINS + 1),
  parameter int DATA_W   = (NUM_PINS > SETUP_W) ? NUM_PINS : SETUP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] gpio_i,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_summary_o
);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(NUM_PINS);

  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] status_q;
  logic [NUM_PINS-1:0] capture_vec;
  logic [NUM_PINS-1:0] report_vec;
  logic [NUM_PINS-1:0] clear_vec;
  pin_setup_t          setup_q [NUM_PINS];

  gib_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(gpio_i),
    .sync_o (pin_sync)
  );

  assign clear_vec = (reg_we && reg_addr == PEND_ADDR) ? reg_wdata[NUM_PINS-1:0] : '0;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) setup_q[p] <= '0;
      else if (reg_we && reg_addr == ADDR_W'(p))
        setup_q[p] <= pin_setup_t'(reg_wdata[SETUP_W-1:0]);
    end

    assign capture_vec[p] = setup_q[p].capture_en;
    assign report_vec[p]  = setup_q[p].report_en;

    gib_pin_detect u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_i  (pin_sync[p]),
      .setup_i  (setup_q[p]),
      .clear_i  (clear_vec[p]),
      .pending_o(status_q[p])
    );
  end

  assign irq_summary_o = |(status_q & report_vec);

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (reg_addr == ADDR_W'(p)) reg_rdata = DATA_W'(setup_q[p]);
    if (reg_addr == PEND_ADDR) reg_rdata = DATA_W'(status_q);
  end
endmodule

// File: rtl/gib_checks.sv
module gib_checks #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic                irq_summary_o,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] capture_vec,
  input logic [NUM_PINS-1:0] report_vec
);
  logic [NUM_PINS-1:0] ack_seen;
  assign ack_seen = (reg_we && reg_addr == ADDR_W'(NUM_PINS)) ? reg_wdata[NUM_PINS-1:0] : '0;

  p_quiet_no_report_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (report_vec == '0) |-> !irq_summary_o);

  p_summary_has_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_summary_o |-> (status_q != '0));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    p_no_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!capture_vec[p] && !status_q[p]) |=> !status_q[p]);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[p] && !ack_seen[p]) |=> status_q[p]);

    p_setup_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(p)) |=>
        (capture_vec[p] == $past(reg_wdata[2]) && report_vec[p] == $past(reg_wdata[3])));
  end
endmodule

bind gpio_irq_bank gib_checks #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .irq_summary_o(irq_summary_o),
  .status_q     (status_q),
  .capture_vec  (capture_vec),
  .report_vec   (report_vec)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
  localparam int N  = 8;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  gpio = '0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_summary_o(irq)
  );

  // Reference model written from the requirements
  logic [N-1:0] m_s1, m_s2, m_hist, m_pend;
  logic [3:0]   m_setup [N];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_hist <= '0; m_pend <= '0;
      for (int i = 0; i < N; i++) m_setup[i] <= '0;
    end else begin
      m_s1 <= gpio;
      m_s2 <= m_s1;
      for (int i = 0; i < N; i++) begin
        logic hit;
        logic clr;
        case (m_setup[i][1:0])
          2'd0: hit = m_s2[i];
          2'd1: hit = !m_s2[i];
          2'd2: hit = m_s2[i] && !m_hist[i];
          default: hit = !m_s2[i] && m_hist[i];
        endcase
        hit = hit && m_setup[i][2];
        clr = reg_we && reg_addr == AW'(N) && reg_wdata[i];
        m_pend[i] <= (m_pend[i] && !clr) || hit;
        m_hist[i] <= m_setup[i][2] ? m_s2[i] : (m_setup[i][1:0] == 2'd3);
      end
      if (reg_we && reg_addr < AW'(N)) m_setup[reg_addr[2:0]] <= reg_wdata[3:0];
    end
  end

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    if (a < AW'(N)) return DW'(m_setup[a[2:0]]);
    if (a == AW'(N)) return m_pend;
    return '0;
  endfunction

  function automatic logic model_irq();
    logic r = 1'b0;
    for (int i = 0; i < N; i++) r |= m_pend[i] && m_setup[i][3];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #3ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 irq", irq, 0);
    rd(0, v); chk("R10 setup0", v, 0);
    rd(8, v); chk("R10 pending", v, 0);

    // R9 register map
    wr(3, 8'hC);
    rd(3, v); chk("R9 setup readback", v, 8'hC);
    rd(9, v); chk("R9 unmapped 9", v, 0);
    rd(15, v); chk("R9 unmapped 15", v, 0);
    wr(3, 8'h0);

    // R1 / R6 level high latency
    wr(0, 8'hC);
    gpio[0] = 1'b1;
    tick(); tick();
    chk("R1 not before edge k+2", irq, 0);
    tick();
    chk("R1 R6 irq at edge k+2", irq, 1);

    // R4 clear while still active re-captures
    wr(8, 8'h01);
    rd(8, v); chk("R4 level recapture", v & 8'h01, 8'h01);
    chk("R4 irq stays", irq, 1);

    // R5 sticky after deassert, cleared by ack
    gpio[0] = 1'b0;
    repeat (5) tick();
    rd(8, v); chk("R5 sticky", v & 8'h01, 8'h01);
    wr(8, 8'h00);
    rd(8, v); chk("R5 zero ack no effect", v & 8'h01, 8'h01);
    wr(8, 8'h01);
    rd(8, v); chk("R5 cleared", v & 8'h01, 0);
    chk("R6 irq low", irq, 0);

    // R1 level low
    wr(1, 8'hD);
    tick();
    rd(8, v); chk("R1 level low fires", v & 8'h02, 8'h02);
    gpio[1] = 1'b1;
    repeat (4) tick();
    wr(8, 8'h02);
    rd(8, v); chk("R1 level low clears when high", v & 8'h02, 0);

    // R2 capture disabled
    wr(1, 8'h8);
    repeat (5) tick();
    rd(8, v); chk("R2 no capture", v & 8'h02, 0);
    chk("R2 irq", irq, 0);

    // R4 clear works once capture is off
    gpio[0] = 1'b1;
    repeat (4) tick();
    rd(8, v); chk("R4 pin0 pending", v & 8'h01, 8'h01);
    wr(0, 8'h8);
    wr(8, 8'h01);
    repeat (3) tick();
    rd(8, v); chk("R4 clear with capture off", v & 8'h01, 0);
    gpio[0] = 1'b0;
    wr(0, 8'h0);

    // R3 capture without report
    wr(2, 8'h4);
    gpio[2] = 1'b1;
    repeat (4) tick();
    rd(8, v); chk("R3 pending set", v & 8'h04, 8'h04);
    chk("R3 irq suppressed", irq, 0);
    wr(2, 8'hC);
    chk("R6 irq on report enable", irq, 1);
    wr(2, 8'h0);
    wr(8, 8'h04);
    gpio[2] = 1'b0;

    // R7 rising edge
    wr(4, 8'hE);
    gpio[4] = 1'b1;
    repeat (4) tick();
    rd(8, v); chk("R7 rise captured", v & 8'h10, 8'h10);
    wr(8, 8'h10);
    repeat (4) tick();
    rd(8, v); chk("R7 held high no recapture", v & 8'h10, 0);
    wr(4, 8'h0);
    gpio[4] = 1'b0;

    // R7 falling edge
    gpio[5] = 1'b1;
    repeat (3) tick();
    wr(5, 8'hF);
    tick();
    rd(8, v); chk("R7 fall quiet while high", v & 8'h20, 0);
    gpio[5] = 1'b0;
    repeat (4) tick();
    rd(8, v); chk("R7 fall captured", v & 8'h20, 8'h20);
    wr(8, 8'h20);
    repeat (3) tick();
    rd(8, v); chk("R7 held low no recapture", v & 8'h20, 0);
    wr(5, 8'h0);

    // R8 spurious capture on enable
    gpio[6] = 1'b1;
    repeat (3) tick();
    wr(6, 8'hA);
    repeat (3) tick();
    rd(8, v); chk("R8 R2 disabled quiet", v & 8'h40, 0);
    wr(6, 8'hE);
    rd(8, v); chk("R8 not yet", v & 8'h40, 0);
    tick();
    rd(8, v); chk("R8 spurious edge", v & 8'h40, 8'h40);
    chk("R8 irq", irq, 1);

    // cleanup
    gpio = '0;
    for (int i = 0; i < N; i++) wr(AW'(i), 8'h0);
    wr(8, 8'hFF);
    repeat (3) tick();
    rd(8, v); chk("R4 all cleared", v, 0);

    // random phase against the reference model (R1..R9)
    for (int n = 0; n < 3000; n++) begin
      int op;
      gpio = N'($urandom);
      op = int'($urandom % 8);
      reg_we = (op < 3);
      reg_addr = (op < 2) ? AW'($urandom % N) : (op == 2) ? AW'(N) : AW'($urandom % (N + 2));
      reg_wdata = DW'($urandom);
      #1;
      chk("R6 random irq", irq, model_irq());
      chk("R9 random read", reg_rdata, model_read(reg_addr));
      @(negedge clk);
    end
    reg_we = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule